// File: doc/BRIEF.md
# Slew-Limited Digital Clock Recovery Loop

This block rebuilds a telecom line clock from a reference input, using nothing but a fast free-running master clock. A 32-bit phase accumulator advances every master cycle by a centre increment for the chosen rate, plus a signed correction. The most significant bit of the accumulator is the recovered clock, so every output edge falls on a master-clock edge. Because all timing comes from the master clock, a ppm error in that clock moves the recovered frequency and the whole lock range by the same ppm.

The reference is sampled through a two-stage synchronizer. A signed phase-error register counts in unit intervals (UI) of the selected rate, with 32 fraction bits. It loses the current increment every master cycle, gains one UI on each reference rising edge, and is pinned at plus or minus 16 UI. On each reference edge a proportional-plus-integral filter, built from arithmetic shifts, computes a target correction. The applied correction then moves toward that target by no more than 61 ppm of centre per update, and it never leaves a clamp of 246 ppm (245 ppm at the 1.544 MHz rate). Slow wander is therefore tracked, but the output phase cannot jump.

All pins are plain level signals. There is no data stream and so no valid/ready handshake or back-pressure: the reference is a raw clock, and the outputs are continuous state that is valid on every master cycle.

Top module: `slew_dpll`

## Requirements
- R1: Reset is synchronous and active high. One master cycle after `rst` is sampled high, `freq_offset` is 0, `locked` is 0 and `clk_out` is 0.
- R2: `ref_sel` encodes the rate: 0 = 8 kHz, 1 = 1.544 MHz, 2 = 2.048 MHz, 3 = 4.096 MHz. The centre increment is floor(f * 2^32 / MCLK_HZ). With no reference edges, `freq_offset` stays 0 and `clk_out` makes floor(N * centre / 2^32) or one more rising edges in N master cycles.
- R3: The internal phase error never exceeds 16 UI in magnitude.
- R4: `freq_offset` changes only in the cycle after a filter update, which happens once per reference rising edge.
- R5: Each change of `freq_offset` (outside reset and selection changes) is at most floor(centre * 61 / 10^6) in magnitude.
- R6: The magnitude of `freq_offset` never exceeds floor(centre * P / 10^6), where P is 245 for `ref_sel` = 1 and 246 otherwise.
- R7: `locked` rises only after 16 consecutive reference updates whose sampled error is within 1 UI. With a nominal-frequency reference it does rise, and with no reference it stays 0.
- R8: A reference update that finds the error saturated clears `locked` on the next cycle.
- R9: One cycle after `ref_sel` changes, `freq_offset` is 0 and `locked` is 0. The phase error and the integrator are cleared at the same time.
- R10: A reference 5% fast drives `freq_offset` to the positive clamp, and one 5% slow drives it to the negative clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sel | input | 2 | Reference rate selection (R2 encoding) |
| ref_in | input | 1 | Reference clock, asynchronous to `clk` |
| clk_out | output | 1 | Recovered clock |
| locked | output | 1 | Lock indicator |
| freq_offset | output | OFF_W | Signed correction added to the centre increment |

## Verification
On every cycle, the embedded properties check the phase-error bound, the hold between updates, the per-update slew step and the clamp. They also check that saturation clears the lock flag, that the flag rises only on an in-window update, and the cleared state after a reset or a change of rate selection. Only the bench scenarios can show the behaviour that depends on the whole loop. These are the free-running output frequency for two rates, the loop actually acquiring lock on a nominal reference, and the correction settling exactly on the positive or negative clamp value when the reference is 5% off.

// File: rtl/dpll_pkg.sv
`timescale 1ns/1ps
package dpll_pkg;

  typedef enum logic [1:0] {
    RATE_8K    = 2'd0,
    RATE_1M544 = 2'd1,
    RATE_2M048 = 2'd2,
    RATE_4M096 = 2'd3
  } rate_sel_e;

  function automatic longint rate_hz(int idx);
    case (idx)
      0:       return 64'd8000;
      1:       return 64'd1544000;
      2:       return 64'd2048000;
      default: return 64'd4096000;
    endcase
  endfunction

  // The 1.544 MHz rate gets a clamp one ppm narrower.
  function automatic longint clamp_ppm(int idx, int base);
    return (idx == 1) ? longint'(base - 1) : longint'(base);
  endfunction

  function automatic longint sat_range(longint v, longint lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/dpll_phase_det.sv
`timescale 1ns/1ps
module dpll_phase_det #(
  parameter int FRAC_W = 32,
  parameter int ERR_W  = 39,
  parameter int SAT_UI = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     ref_in,
  input  logic [FRAC_W-1:0]        inc,
  output logic signed [ERR_W-1:0]  err,
  output logic                     smp_valid,
  output logic                     smp_sat
);
  localparam longint SAT_V = longint'(SAT_UI) <<< FRAC_W;
  localparam longint ONE_V = 64'sd1 <<< FRAC_W;

  logic [2:0]          sync_q;
  logic                ref_rise;
  logic                hit_q;
  logic signed [63:0]  raw;
  logic signed [63:0]  lim;
  logic                hit_now;

  assign ref_rise = sync_q[1] & ~sync_q[2];

  always_comb begin
    raw     = longint'(err) - longint'(inc) + (ref_rise ? ONE_V : 64'sd0);
    lim     = dpll_pkg::sat_range(raw, SAT_V);
    hit_now = (raw >= SAT_V) || (raw <= -SAT_V);
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], ref_in};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err       <= '0;
      smp_valid <= 1'b0;
      smp_sat   <= 1'b0;
      hit_q     <= 1'b0;
    end else begin
      err       <= ERR_W'(lim);
      smp_valid <= ref_rise;
      smp_sat   <= ref_rise && (hit_q || hit_now);
      hit_q     <= ref_rise ? 1'b0 : (hit_q || hit_now);
    end
  end

  // R3: a saturation report only ever accompanies a sample
  a_r3_sat_with_sample: assert property (@(posedge clk) disable iff (rst)
    smp_sat |-> smp_valid);

endmodule

// File: rtl/dpll_loop_filter.sv
`timescale 1ns/1ps
module dpll_loop_filter #(
  parameter int ERR_W    = 39,
  parameter int OFF_W    = 32,
  parameter int SH_W     = 7,
  parameter int KI_EXTRA = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     upd,
  input  logic signed [ERR_W-1:0]  err,
  input  logic [SH_W-1:0]          kp,
  input  logic signed [OFF_W-1:0]  limit,
  input  logic [OFF_W-1:0]         slew,
  output logic signed [OFF_W-1:0]  offset
);
  logic signed [OFF_W-1:0] integ;
  logic signed [63:0] e_w, p_term, i_term, i_new, target, step;

  always_comb begin
    e_w    = longint'(err);
    p_term = e_w >>> int'(kp);
    i_term = e_w >>> (int'(kp) + KI_EXTRA);
    i_new  = dpll_pkg::sat_range(longint'(integ) + i_term, longint'(limit));
    target = dpll_pkg::sat_range(p_term + i_new, longint'(limit));
    step   = dpll_pkg::sat_range(target - longint'(offset), longint'(slew));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      integ  <= '0;
      offset <= '0;
    end else if (upd) begin
      integ  <= OFF_W'(i_new);
      offset <= OFF_W'(longint'(offset) + step);
    end
  end

  // R4: no movement without an update
  a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr) && !$past(upd)) |-> $stable(offset));

  // R5: bounded step per update
  a_r5_slew_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr)) |->
      ((longint'(offset) - longint'($past(offset)) <= longint'(slew)) &&
       (longint'($past(offset)) - longint'(offset) <= longint'(slew))));

  // R6: correction stays inside the lock range
  a_r6_clamp: assert property (@(posedge clk) disable iff (rst || clr)
    (offset <= limit) && (offset >= -limit));

endmodule

// File: rtl/dpll_lock_det.sv
`timescale 1ns/1ps
module dpll_lock_det #(
  parameter int FRAC_W     = 32,
  parameter int ERR_W      = 39,
  parameter int LOCK_UI    = 1,
  parameter int LOCK_COUNT = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     upd,
  input  logic                     sat,
  input  logic signed [ERR_W-1:0]  err,
  output logic                     locked
);
  localparam int CNT_W = $clog2(LOCK_COUNT + 1);
  localparam logic signed [ERR_W-1:0] WIN = ERR_W'(longint'(LOCK_UI) <<< FRAC_W);

  logic [CNT_W-1:0] cnt;
  logic             in_win;

  assign in_win = (err <= WIN) && (err >= -WIN);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (upd) begin
      if (sat) begin
        cnt    <= '0;
        locked <= 1'b0;
      end else if (in_win) begin
        if (cnt != CNT_W'(LOCK_COUNT)) cnt <= cnt + 1'b1;
        if (cnt >= CNT_W'(LOCK_COUNT - 1)) locked <= 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end

  // R8: saturation drops lock
  a_r8_sat_unlock: assert property (@(posedge clk) disable iff (rst)
    (upd && sat) |=> !locked);

  // R7: lock rises only on an in-window update
  a_r7_lock_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(upd && !sat && in_win));

endmodule

// File: rtl/dpll_dco.sv
`timescale 1ns/1ps
module dpll_dco #(
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [FRAC_W-1:0] inc,
  output logic              clk_out
);
  logic [FRAC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc     <= '0;
      clk_out <= 1'b0;
    end else begin
      acc     <= acc + inc;
      clk_out <= acc[FRAC_W-1];
    end
  end
endmodule

// File: rtl/slew_dpll.sv
`timescale 1ns/1ps
module slew_dpll #(
  parameter int MCLK_HZ    = 50_000_000,
  parameter int FRAC_W     = 32,
  parameter int OFF_W      = 32,
  parameter int SAT_UI     = 16,
  parameter int LOCK_UI    = 1,
  parameter int LOCK_COUNT = 16,
  parameter int SLEW_PPM   = 61,
  parameter int CLAMP_PPM  = 246
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              ref_sel,
  input  logic                    ref_in,
  output logic                    clk_out,
  output logic                    locked,
  output logic signed [OFF_W-1:0] freq_offset
);
  localparam int ERR_W = FRAC_W + $clog2(SAT_UI) + 3;
  localparam int SH_W  = 7;
  localparam int NRATE = 4;
  localparam longint SAT_V = longint'(SAT_UI) <<< FRAC_W;

  logic [FRAC_W-1:0]        centre_tab [NRATE];
  logic signed [OFF_W-1:0]  limit_tab  [NRATE];
  logic [OFF_W-1:0]         slew_tab   [NRATE];
  logic [SH_W-1:0]          kp_tab     [NRATE];

  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    localparam longint HZ  = dpll_pkg::rate_hz(g);
    localparam longint CEN = (HZ <<< FRAC_W) / longint'(MCLK_HZ);
    localparam longint LIM = CEN * dpll_pkg::clamp_ppm(g, CLAMP_PPM) / 64'd1000000;
    localparam longint SLW = CEN * longint'(SLEW_PPM) / 64'd1000000;
    localparam int     KP  = $clog2(MCLK_HZ / int'(HZ)) + 3;
    assign centre_tab[g] = FRAC_W'(CEN);
    assign limit_tab[g]  = OFF_W'(LIM);
    assign slew_tab[g]   = OFF_W'(SLW);
    assign kp_tab[g]     = SH_W'(KP);
  end

  dpll_pkg::rate_sel_e sel_q;
  logic                sel_chg;
  logic [FRAC_W-1:0]   inc;
  logic signed [ERR_W-1:0] pd_err;
  logic                pd_valid;
  logic                pd_sat;

  always_ff @(posedge clk) sel_q <= dpll_pkg::rate_sel_e'(ref_sel);

  assign sel_chg = (sel_q != dpll_pkg::rate_sel_e'(ref_sel));
  assign inc     = centre_tab[ref_sel] + FRAC_W'(freq_offset);

  dpll_phase_det #(.FRAC_W(FRAC_W), .ERR_W(ERR_W), .SAT_UI(SAT_UI)) u_pd (
    .clk(clk), .rst(rst), .clr(sel_chg), .ref_in(ref_in), .inc(inc),
    .err(pd_err), .smp_valid(pd_valid), .smp_sat(pd_sat));

  dpll_loop_filter #(.ERR_W(ERR_W), .OFF_W(OFF_W), .SH_W(SH_W)) u_lf (
    .clk(clk), .rst(rst), .clr(sel_chg), .upd(pd_valid), .err(pd_err),
    .kp(kp_tab[ref_sel]), .limit(limit_tab[ref_sel]), .slew(slew_tab[ref_sel]),
    .offset(freq_offset));

  dpll_lock_det #(.FRAC_W(FRAC_W), .ERR_W(ERR_W), .LOCK_UI(LOCK_UI),
                  .LOCK_COUNT(LOCK_COUNT)) u_ld (
    .clk(clk), .rst(rst), .clr(sel_chg), .upd(pd_valid), .sat(pd_sat),
    .err(pd_err), .locked(locked));

  dpll_dco #(.FRAC_W(FRAC_W)) u_dco (
    .clk(clk), .rst(rst), .clr(sel_chg), .inc(inc), .clk_out(clk_out));

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (freq_offset == '0) && !locked && !clk_out);

  // R9: rate change clears the loop
  a_r9_sel_clear: assert property (@(posedge clk) disable iff (rst)
    sel_chg |=> (freq_offset == '0) && !locked);

  // R3: phase error bounded
  a_r3_err_bounded: assert property (@(posedge clk) disable iff (rst)
    (longint'(pd_err) <= SAT_V) && (longint'(pd_err) >= -SAT_V));

endmodule

// File: tb/slew_dpll_tb.sv
`timescale 1ns/1ps
module slew_dpll_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ref_sel = 2'd3;
  logic        ref_in = 1'b0;
  logic        clk_out;
  logic        locked;
  logic signed [31:0] freq_offset;

  bit      ref_en = 1'b0;
  realtime ref_half = 122.0;
  int      n_chk = 0, n_bad = 0;
  int      slew_bad = 0, lim_bad = 0, rise_cnt = 0;
  longint  prev_off = 0;
  bit      skip = 1'b1;
  logic    last_co = 1'b0;

  always #10 clk = ~clk;

  always begin
    if (ref_en) begin
      #(ref_half);
      ref_in = ~ref_in;
    end else begin
      ref_in = 1'b0;
      #7;
    end
  end

  slew_dpll u_dut (.clk(clk), .rst(rst), .ref_sel(ref_sel), .ref_in(ref_in),
                   .clk_out(clk_out), .locked(locked), .freq_offset(freq_offset));

  function automatic longint hz_of(int s);
    case (s) 0: return 8000; 1: return 1544000; 2: return 2048000; default: return 4096000; endcase
  endfunction
  function automatic longint centre_of(int s);
    return (hz_of(s) * 64'd4294967296) / 64'd50000000;
  endfunction
  function automatic longint lim_of(int s);
    return centre_of(s) * ((s == 1) ? 64'd245 : 64'd246) / 64'd1000000;
  endfunction
  function automatic longint slew_of(int s);
    return centre_of(s) * 64'd61 / 64'd1000000;
  endfunction
  function automatic longint mag(longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(string tag, longint act, longint lo, longint hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!skip && mag(longint'(freq_offset) - prev_off) > slew_of(int'(ref_sel))) slew_bad++;
      if (mag(longint'(freq_offset)) > lim_of(int'(ref_sel))) lim_bad++;
      if (clk_out && !last_co) rise_cnt++;
      last_co  = clk_out;
      prev_off = longint'(freq_offset);
      skip     = 1'b0;
    end
  endtask

  task automatic set_sel(int s);
    @(negedge clk);
    ref_sel = 2'(s);
    skip = 1'b1;
  endtask

  task automatic set_ref(int s, real frac);
    ref_half = 1.0e9 / (real'(hz_of(s)) * (1.0 + frac)) / 2.0;
    ref_en = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1; ref_en = 1'b0; ref_sel = 2'd3;
    repeat (3) @(negedge clk);
    check("R1 offset", longint'(freq_offset), 0, 0);
    check("R1 locked", longint'(locked), 0, 0);
    check("R1 clk_out", longint'(clk_out), 0, 0);
    rst = 1'b0; skip = 1'b1;
  endtask

  task automatic t_freerun(int s);
    longint e;
    ref_en = 1'b0;
    set_sel(s);
    run(5);
    rise_cnt = 0;
    run(30000);
    e = (64'd30000 * centre_of(s)) >> 32;
    check("R2 clk_out edges", rise_cnt, e, e + 1);
    check("R2 offset without reference", longint'(freq_offset), 0, 0);
    check("R7 no lock without reference", longint'(locked), 0, 0);
  endtask

  task automatic t_lock(int s);
    set_ref(s, 0.0);
    set_sel(s);
    slew_bad = 0; lim_bad = 0;
    for (int i = 0; i < 30000 && !locked; i++) run(1);
    check("R7 lock on nominal reference", longint'(locked), 1, 1);
    check("R5 slew steps", slew_bad, 0, 0);
    check("R6 clamp", lim_bad, 0, 0);
  endtask

  task automatic t_fast();
    t_lock(3);
    set_ref(3, 0.05);
    slew_bad = 0;
    run(10000);
    check("R8 lock lost on saturation", longint'(locked), 0, 0);
    check("R10 positive clamp", longint'(freq_offset), lim_of(3), lim_of(3));
    check("R5 slew while pulling", slew_bad, 0, 0);
  endtask

  task automatic t_selchg();
    t_lock(2);
    @(negedge clk);
    ref_sel = 2'd1;
    skip = 1'b1;
    @(negedge clk);
    check("R9 offset cleared", longint'(freq_offset), 0, 0);
    check("R9 lock cleared", longint'(locked), 0, 0);
  endtask

  task automatic t_slow();
    set_ref(1, -0.05);
    set_sel(0);
    set_sel(1);
    lim_bad = 0;
    run(22000);
    check("R10 negative clamp", longint'(freq_offset), -lim_of(1), -lim_of(1));
    check("R8 no lock when saturated", longint'(locked), 0, 0);
    check("R6 clamp 245 ppm", lim_bad, 0, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_freerun(3);
    t_freerun(1);
    t_lock(2);
    t_fast();
    t_selchg();
    t_slow();
    summary();
    $finish;
  end
endmodule